// File: doc/BRIEF.md
# Chained Descriptor Transmit DMA

This engine walks a ring of transmit descriptors in memory and streams each descriptor's buffer out as bytes. Every descriptor is four 32-bit words. The first word holds the ownership flag. The second holds the byte count and the segment flags. The third points at the buffer. The fourth points at the next descriptor, so the last entry of the ring points back to the first. Software fills the descriptors, hands them over by setting the ownership flag, and starts the engine. The engine sends each buffer on a byte-wide valid/ready stream that carries frame start and frame end markers. It then returns the descriptor by writing its first word back with ownership cleared.

When the engine fetches a descriptor it does not own, it reports that no buffer is available and waits. A poll demand makes it read the same descriptor again. Clearing the run bit stops the engine at the next descriptor boundary. A small register port holds the list base, the control bits, the status flags and an interrupt mask. A single 32-bit memory port with request/acknowledge carries all descriptor and buffer traffic.

Top module: `txdesc_dma`

## Requirements
- R1: After reset no memory request, no stream byte and no interrupt is driven, and the status register reads 0.
- R2: Writing control bit 30 from 0 to 1 (register index 1) starts the engine. Its first memory access is a read of the list base held in register index 0.
- R3: A buffer of N bytes (word1 bits 10:0) read from the word2 address appears as N stream bytes in address order, least significant byte of each 32-bit word first.
- R4: The start marker accompanies the first byte of a descriptor whose word1 bit 29 is set. The end marker accompanies the final byte of a descriptor whose word1 bit 30 is set. A frame may span several descriptors.
- R5: After its buffer is sent, a descriptor's word0 is written back with bit 31 cleared. Only after that write is the descriptor at the word3 address read.
- R6: A fetched word0 with bit 31 clear sets status bit 2 (buffer unavailable), and the engine then makes no memory request.
- R7: Writing 1 to control bit 31 while suspended re-reads the same descriptor address.
- R8: A zero-length descriptor emits no bytes but is still written back.
- R9: Status bit 0 (transmit complete) is set when a descriptor is written back only if its word1 bits 30 (last) and 31 (interrupt) are both set.
- R10: Writing 1 to a status bit (register index 2) clears it. An event in the same cycle as the clear leaves the bit set.
- R11: The interrupt output is high exactly when a status bit is set whose bit in the enable register (index 3) is also set.
- R12: Clearing control bit 30 lets the current descriptor finish and be written back. The engine then sets status bit 1 (stopped) and fetches nothing more.
- R13: While a byte is offered and not accepted, the data and valid stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index: 0 base, 1 control, 2 status, 3 enable |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Memory write when high, read when low |
| mem_addr_o | output | 32 | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |
| tx_data_o | output | 8 | Stream byte |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_first_o | output | 1 | Frame start marker |
| tx_last_o | output | 1 | Frame end marker |
| tx_ready_i | input | 1 | Stream sink ready |
| irq_o | output | 1 | Interrupt request |

## Verification
Two paths can act on the transmit-complete flag in the same cycle: the write-back of a finished descriptor sets it, and a write-1-to-clear from software clears it. The bench sweeps the clear write across sixteen cycle offsets after a poll. It records the cycle in which its memory model acknowledges the write-back and the cycle in which the clear is sampled. It expects the flag to remain set whenever the write-back cycle is not earlier than the clear cycle. A length sweep from 0 to 9 bytes under varied backpressure also makes each word boundary coincide with the end of a buffer.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_D0, S_D1, S_D2, S_D3, S_BRD, S_BOUT, S_WB, S_SUSP
  } eng_state_e;

  localparam int OWN_BIT   = 31;
  localparam int FS_BIT    = 29;
  localparam int LS_BIT    = 30;
  localparam int IC_BIT    = 31;
  localparam int RUN_BIT   = 30;
  localparam int POLL_BIT  = 31;
  localparam int EV_DONE   = 0;
  localparam int EV_STOP   = 1;
  localparam int EV_UNAV   = 2;
  localparam int NUM_EV    = 3;
  localparam logic [1:0] RA_BASE = 2'd0;
  localparam logic [1:0] RA_CTRL = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;
  localparam logic [1:0] RA_EN   = 2'd3;
endpackage

// File: rtl/txdesc_regs.sv
module txdesc_regs
  import txdesc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [DW-1:0]     base_o,
  output logic              run_o,
  output logic              start_o,
  output logic              poll_o,
  input  logic [NUM_EV-1:0] evt_i,
  output logic              irq_o
);
  logic [DW-1:0]     base_q;
  logic              run_q;
  logic [NUM_EV-1:0] stat_q, en_q, clr;
  logic              ctrl_wr;

  assign ctrl_wr = wr_i && (addr_i == RA_CTRL);
  assign start_o = ctrl_wr && wdata_i[RUN_BIT] && !run_q;
  assign poll_o  = ctrl_wr && wdata_i[POLL_BIT];
  assign clr     = (wr_i && addr_i == RA_STAT) ? wdata_i[NUM_EV-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      run_q  <= 1'b0;
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      if (wr_i && addr_i == RA_BASE) base_q <= wdata_i;
      if (ctrl_wr) run_q <= wdata_i[RUN_BIT];
      if (wr_i && addr_i == RA_EN) en_q <= wdata_i[NUM_EV-1:0];
      stat_q <= (stat_q & ~clr) | evt_i;  // set wins
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_BASE: rdata_o = base_q;
      RA_CTRL: rdata_o[RUN_BIT] = run_q;
      RA_STAT: rdata_o[NUM_EV-1:0] = stat_q;
      default: rdata_o[NUM_EV-1:0] = en_q;
    endcase
  end

  assign base_o = base_q;
  assign run_o  = run_q;
  assign irq_o  = |(stat_q & en_q);

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[EV_DONE] |=> stat_q[EV_DONE]);
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == RA_STAT && wdata_i[EV_DONE] && !evt_i[EV_DONE]) |=> !stat_q[EV_DONE]);
endmodule

// File: rtl/txdesc_unpack.sv
module txdesc_unpack #(
  parameter int DW = 32,
  parameter int BW = 8,
  parameter int CW = $clog2(DW/BW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [DW-1:0] word_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          ready_i,
  output logic [BW-1:0] data_o,
  output logic          valid_o,
  output logic          last_o,
  output logic          take_o
);
  logic [DW-1:0] word_q;
  logic [CW-1:0] cnt_q;

  assign valid_o = (cnt_q != '0);
  assign data_o  = word_q[BW-1:0];
  assign last_o  = (cnt_q == CW'(1));
  assign take_o  = valid_o && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (ld_i) begin
      word_q <= word_i;
      cnt_q  <= cnt_i;
    end else if (take_o) begin
      word_q <= word_q >> BW;
      cnt_q  <= cnt_q - CW'(1);
    end
  end

  a_r13_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !ld_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/txdesc_engine.sv
module txdesc_engine
  import txdesc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int LENW = 11,
  parameter int NB   = 4,
  parameter int CW   = $clog2(NB + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              start_i,
  input  logic              poll_i,
  input  logic [AW-1:0]     base_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              ld_o,
  output logic [CW-1:0]     ld_cnt_o,
  input  logic              take_i,
  input  logic              word_last_i,
  output logic              first_o,
  output logic              last_o,
  output logic [NUM_EV-1:0] evt_o
);
  localparam logic [AW-1:0] WSTEP = AW'(DW/8);

  eng_state_e    st_q;
  logic [AW-1:0] cur_q, nxt_q, bptr_q;
  logic [30:0]   w0_q;
  logic [LENW-1:0] rem_q;
  logic          fs_q, ls_q, ic_q, sent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;
      cur_q <= '0; nxt_q <= '0; bptr_q <= '0; w0_q <= '0;
      rem_q <= '0; fs_q <= 1'b0; ls_q <= 1'b0; ic_q <= 1'b0; sent_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          cur_q <= base_i;
          st_q  <= S_D0;
        end
        S_D0: if (mem_ack_i) begin
          if (!mem_rdata_i[OWN_BIT]) st_q <= S_SUSP;
          else begin
            w0_q <= mem_rdata_i[30:0];
            st_q <= S_D1;
          end
        end
        S_D1: if (mem_ack_i) begin
          rem_q  <= mem_rdata_i[LENW-1:0];
          fs_q   <= mem_rdata_i[FS_BIT];
          ls_q   <= mem_rdata_i[LS_BIT];
          ic_q   <= mem_rdata_i[IC_BIT];
          sent_q <= 1'b0;
          st_q   <= S_D2;
        end
        S_D2: if (mem_ack_i) begin
          bptr_q <= mem_rdata_i;
          st_q   <= S_D3;
        end
        S_D3: if (mem_ack_i) begin
          nxt_q <= mem_rdata_i;
          st_q  <= (rem_q == '0) ? S_WB : S_BRD;
        end
        S_BRD: if (mem_ack_i) begin
          bptr_q <= bptr_q + WSTEP;
          st_q   <= S_BOUT;
        end
        S_BOUT: if (take_i) begin
          rem_q  <= rem_q - LENW'(1);
          sent_q <= 1'b1;
          if (word_last_i) st_q <= (rem_q == LENW'(1)) ? S_WB : S_BRD;
        end
        S_WB: if (mem_ack_i) begin
          cur_q <= nxt_q;
          st_q  <= run_i ? S_D0 : S_IDLE;
        end
        S_SUSP: begin
          if (!run_i)      st_q <= S_IDLE;
          else if (poll_i) st_q <= S_D0;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o  = 1'b0;
    mem_addr_o = cur_q;
    case (st_q)
      S_D0:  begin mem_req_o = 1'b1; mem_addr_o = cur_q; end
      S_D1:  begin mem_req_o = 1'b1; mem_addr_o = cur_q + WSTEP; end
      S_D2:  begin mem_req_o = 1'b1; mem_addr_o = cur_q + 2 * WSTEP; end
      S_D3:  begin mem_req_o = 1'b1; mem_addr_o = cur_q + 3 * WSTEP; end
      S_BRD: begin mem_req_o = 1'b1; mem_addr_o = bptr_q; end
      S_WB:  begin mem_req_o = 1'b1; mem_addr_o = cur_q; end
      default: ;
    endcase
  end

  assign mem_we_o    = (st_q == S_WB);
  assign mem_wdata_o = {1'b0, w0_q};
  assign ld_o        = (st_q == S_BRD) && mem_ack_i;
  assign ld_cnt_o    = (rem_q >= LENW'(NB)) ? CW'(NB) : rem_q[CW-1:0];
  assign first_o     = (st_q == S_BOUT) && fs_q && !sent_q;
  assign last_o      = (st_q == S_BOUT) && ls_q && (rem_q == LENW'(1));

  assign evt_o[EV_DONE] = (st_q == S_WB) && mem_ack_i && ls_q && ic_q;
  assign evt_o[EV_STOP] = ((st_q == S_WB) && mem_ack_i && !run_i) ||
                          ((st_q == S_SUSP) && !run_i);
  assign evt_o[EV_UNAV] = (st_q == S_D0) && mem_ack_i && !mem_rdata_i[OWN_BIT];

  a_r1_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  a_r5_wb_own_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> !mem_wdata_o[OWN_BIT]);
  a_r6_susp_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o[EV_UNAV] |=> !mem_req_o);
  a_r8_no_excess_bytes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (rem_q != '0));
  a_r12_stop_needs_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o[EV_STOP] |-> !run_i);
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
  import txdesc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int BW   = 8,
  parameter int LENW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [BW-1:0] tx_data_o,
  output logic          tx_valid_o,
  output logic          tx_first_o,
  output logic          tx_last_o,
  input  logic          tx_ready_i,
  output logic          irq_o
);
  localparam int NB = DW / BW;
  localparam int CW = $clog2(NB + 1);

  logic [DW-1:0]     base;
  logic              run, start, poll, ld, take, wlast, eng_first, eng_last;
  logic [CW-1:0]     ld_cnt;
  logic [NUM_EV-1:0] evt;

  txdesc_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni, .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .base_o(base), .run_o(run), .start_o(start),
    .poll_o(poll), .evt_i(evt), .irq_o
  );

  txdesc_engine #(.AW(AW), .DW(DW), .LENW(LENW), .NB(NB), .CW(CW)) u_eng (
    .clk_i, .rst_ni, .run_i(run), .start_i(start), .poll_i(poll), .base_i(base),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .ld_o(ld), .ld_cnt_o(ld_cnt), .take_i(take), .word_last_i(wlast),
    .first_o(eng_first), .last_o(eng_last), .evt_o(evt)
  );

  txdesc_unpack #(.DW(DW), .BW(BW), .CW(CW)) u_unpack (
    .clk_i, .rst_ni, .ld_i(ld), .word_i(mem_rdata_i), .cnt_i(ld_cnt),
    .ready_i(tx_ready_i), .data_o(tx_data_o), .valid_o(tx_valid_o),
    .last_o(wlast), .take_o(take)
  );

  assign tx_first_o = eng_first && tx_valid_o;
  assign tx_last_o  = eng_last && tx_valid_o;
endmodule

// File: tb/sim_txdesc_dma.sv
module sim_txdesc_dma;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RUN = 32'h4000_0000;
  localparam logic [31:0] POLL = 32'h8000_0000;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] FS = 32'h2000_0000, LS = 32'h4000_0000, IC = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [7:0] tx_data;
  logic tx_valid, tx_first, tx_last, tx_ready = 1'b1, irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  txdesc_dma u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .tx_data_o(tx_data),
    .tx_valid_o(tx_valid), .tx_first_o(tx_first), .tx_last_o(tx_last),
    .tx_ready_i(tx_ready), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] mem [0:255];
  logic [31:0] op_addr [0:511];
  bit op_we [0:511];
  int n_ops = 0, wb_cyc = 0, clr_cyc = 0;
  logic [7:0] rx_b [0:63];
  bit rx_f [0:63];
  bit rx_l [0:63];
  int rx_n = 0, rdy_mode = 0, hold_err = 0;

  function automatic logic [7:0] byte_at(input int a);
    return 8'((a * 13 + 5) & 255);
  endfunction

  // memory model: one-cycle acknowledge, driven on the falling edge
  initial forever begin
    @(negedge clk);
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        mem[mem_addr[9:2]] = mem_wdata;
        wb_cyc = cyc;
      end else mem_rdata = mem[mem_addr[9:2]];
      if (n_ops < 512) begin
        op_addr[n_ops] = mem_addr;
        op_we[n_ops] = mem_we;
      end
      n_ops++;
    end
  end

  // stream sink with backpressure pattern
  initial begin
    bit stall = 1'b0;
    logic [7:0] pdata = '0;
    forever begin
      @(negedge clk);
      if (stall && !(tx_valid && tx_data == pdata)) hold_err++;
      tx_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % rdy_mode) != 0);
      if (tx_valid && tx_ready && rx_n < 64) begin
        rx_b[rx_n] = tx_data;
        rx_f[rx_n] = tx_first;
        rx_l[rx_n] = tx_last;
        rx_n++;
      end
      stall = tx_valid && !tx_ready;
      pdata = tx_data;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; clr_cyc = cyc;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_stat(input int b);
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      reg_read(2'd2, s);
      if (s[b]) break;
    end
  endtask

  task automatic set_desc(input int at, input logic [31:0] w0, input int len,
                          input logic [31:0] flags, input int buf_a, input int nxt);
    mem[at/4]     = w0;
    mem[at/4 + 1] = flags | 32'h0100_0000 | 32'(len);
    mem[at/4 + 2] = 32'(buf_a);
    mem[at/4 + 3] = 32'(nxt);
  endtask

  task automatic check_bytes(input string tag, input int base_a, input int off, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) if (rx_b[off + i] != byte_at(base_a + i)) bad++;
    chk(tag, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] s;
    int nf, nl, q, nb;
    for (int i = 0; i < 256; i++)
      mem[i] = {byte_at(4*i+3), byte_at(4*i+2), byte_at(4*i+1), byte_at(4*i)};
    repeat (3) @(negedge clk);
    chk("R1 mem_req at reset", int'(mem_req), 0);
    chk("R1 tx_valid at reset", int'(tx_valid), 0);
    chk("R1 irq at reset", int'(irq), 0);
    rst_n = 1'b1;
    reg_read(2'd2, s);
    chk("R1 status after reset", int'(s), 0);
    reg_write(2'd3, 32'd7);

    // length sweep 0..9 through a one-entry ring
    for (int len = 0; len < 10; len++) begin
      rdy_mode = (len % 3 == 0) ? 0 : (len % 3) + 1;
      set_desc(32'h40, OWN, len, FS | LS | IC, 32'h100, 32'h40);
      rx_n = 0; n_ops = 0;
      if (len == 0) begin
        reg_write(2'd0, 32'h40);
        reg_write(2'd1, RUN);
      end else reg_write(2'd1, RUN | POLL);
      wait_stat(2);
      chk(len == 0 ? "R2 first read at base" : "R7 poll re-reads same descriptor",
          int'(op_addr[0]) + (op_we[0] ? 1 : 0), 32'h40);
      chk(len == 0 ? "R8 zero length emits nothing" : "R3 byte count", rx_n, len);
      check_bytes("R3 byte order", 32'h100, 0, len);
      nf = 0; nl = 0;
      for (int i = 0; i < rx_n; i++) begin
        nf += int'(rx_f[i]) * (i == 0 ? 1 : 100);
        nl += int'(rx_l[i]) * (i == rx_n - 1 ? 1 : 100);
      end
      chk("R4 start marker", nf, len > 0 ? 1 : 0);
      chk("R4 end marker", nl, len > 0 ? 1 : 0);
      chk("R5 own cleared", int'(mem[16][31]), 0);
      q = 4 + (len + 3) / 4;
      chk(len == 0 ? "R8 write-back of empty descriptor" : "R5 write-back position",
          int'(op_we[q]) * 1000 + int'(op_addr[q]), 1000 + 32'h40);
      chk("R5 next read after write-back", int'(op_we[q+1]) * 1000 + int'(op_addr[q+1]), 32'h40);
      reg_read(2'd2, s);
      chk("R9 R6 status done and unavailable", int'(s), 5);
      chk("R11 irq with enabled status", int'(irq), 1);
      nb = n_ops;
      repeat (20) @(negedge clk);
      chk("R6 no request while suspended", n_ops, nb);
      reg_write(2'd2, 32'd7);
      reg_read(2'd2, s);
      chk("R10 write-1-to-clear", int'(s), 0);
      chk("R11 irq drops after clear", int'(irq), 0);
    end

    // last without interrupt flag, irq masked to done only
    reg_write(2'd3, 32'd1);
    set_desc(32'h40, OWN, 2, FS | LS, 32'h104, 32'h40);
    rx_n = 0; rdy_mode = 0;
    reg_write(2'd1, RUN | POLL);
    wait_stat(2);
    reg_read(2'd2, s);
    chk("R9 no done without interrupt flag", int'(s[0]), 0);
    chk("R11 masked unavailable gives no irq", int'(irq), 0);
    chk("R4 end marker without interrupt flag", int'(rx_l[1]), 1);
    check_bytes("R3 offset buffer", 32'h104, 0, 2);
    reg_write(2'd3, 32'd7);
    reg_write(2'd2, 32'd7);

    // frame spanning three chained descriptors
    set_desc(32'h40, OWN, 3, FS, 32'h100, 32'h50);
    set_desc(32'h50, OWN, 5, 32'h0, 32'h140, 32'h60);
    set_desc(32'h60, OWN, 2, LS | IC, 32'h180, 32'h40);
    rx_n = 0; n_ops = 0; rdy_mode = 2;
    reg_write(2'd1, RUN | POLL);
    wait_stat(2);
    chk("R3 chained byte count", rx_n, 10);
    check_bytes("R3 chained first buffer", 32'h100, 0, 3);
    check_bytes("R3 chained second buffer", 32'h140, 3, 5);
    check_bytes("R3 chained third buffer", 32'h180, 8, 2);
    nf = 0; nl = 0;
    for (int i = 0; i < 10; i++) begin
      nf += int'(rx_f[i]) * (i == 0 ? 1 : 100);
      nl += int'(rx_l[i]) * (i == 9 ? 1 : 100);
    end
    chk("R4 multi-descriptor start marker", nf, 1);
    chk("R4 multi-descriptor end marker", nl, 1);
    q = -1;
    for (int i = 0; i < n_ops && i < 511; i++)
      if (q < 0 && op_we[i] && op_addr[i] == 32'h40) q = i;
    chk("R5 next pointer followed after write-back",
        (q >= 0) ? int'(op_addr[q+1]) + int'(op_we[q+1]) : -1, 32'h50);
    reg_read(2'd2, s);
    chk("R9 done on last with interrupt", int'(s[0]), 1);

    // clear versus completion in the same cycle
    for (int k = 0; k < 16; k++) begin
      reg_write(2'd2, 32'd7);
      set_desc(32'h40, OWN, 1, FS | LS | IC, 32'h100, 32'h40);
      rdy_mode = 0;
      reg_write(2'd1, RUN | POLL);
      repeat (k) @(negedge clk);
      reg_write(2'd2, 32'd1);
      wait_stat(2);
      reg_read(2'd2, s);
      chk($sformatf("R10 set versus clear offset %0d", k), int'(s[0]),
          (wb_cyc >= clr_cyc) ? 1 : 0);
    end

    // stop at descriptor boundary
    reg_write(2'd2, 32'd7);
    set_desc(32'h40, OWN, 8, FS | LS | IC, 32'h100, 32'h50);
    set_desc(32'h50, OWN, 4, FS | LS | IC, 32'h140, 32'h40);
    rx_n = 0; n_ops = 0; rdy_mode = 3;
    reg_write(2'd1, RUN | POLL);
    for (int i = 0; i < 2000 && rx_n < 2; i++) @(negedge clk);
    reg_write(2'd1, 32'h0);
    wait_stat(1);
    chk("R12 current buffer completes", rx_n, 8);
    chk("R12 current descriptor returned", int'(mem[16][31]), 0);
    nb = 0;
    for (int i = 0; i < n_ops && i < 512; i++) if (op_addr[i] == 32'h50) nb++;
    chk("R12 no fetch after stop", nb, 0);
    nb = n_ops;
    repeat (20) @(negedge clk);
    chk("R12 idle after stop", n_ops, nb);
    chk("R13 stalled byte held", hold_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule